// File: doc/BRIEF.md
# External Bus Access State Controller

This block decides, for each external bus access, how many bus states the access takes, and then steps through those states. Eight address areas each carry one bit that chooses a short access (two states) or a long access (three states). Each area also has a 2-bit programmable wait count. That count adds wait states between the second state and the final state, but only when the area uses the long access. Accesses to on-chip memory or registers always take a fixed two states. Accesses flagged as DRAM get no states from this block. Instead they are handed to an external DRAM controller through a one-cycle request pulse.

The settings live in three 8-bit registers behind a plain register port. There is one register of access-length bits and two registers of wait counts. A reset or the hardware-standby input sets all three to 0xFF. The software-standby input leaves them unchanged.

Accesses enter on a valid/ready handshake. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is high only when no access is in progress and neither standby input is active. The block has no buffering: a request presented while `acc_ready` is low is simply not taken, and the requester must hold it or present it again. The area number and flags are sampled only on the accepting edge. The area's settings are frozen at that edge too, so later register writes affect only later accesses.

Top module: `ext_bus_state_ctrl`

## Requirements
- R1: The register port has three registers: access-length bits at `reg_addr` 0, upper wait counts at 1 and lower wait counts at 2. A write happens on a clock edge with `reg_wr` high. `reg_rdata` shows the register selected by `reg_addr` without delay. Address 3 reads as 0x00, and writes to it change nothing.
- R2: While `rst_n` is low, and on any edge with `hw_stby` high, all three registers become 0xFF and the sequencer returns to idle. A register write on an edge with `hw_stby` high is lost.
- R3: `sw_stby` never alters the registers. While it is high, `acc_ready` is low and no access starts.
- R4: Bit n of the access-length register controls area n. A 0 gives a two-state access (T1, T2). A 1 gives a three-state access.
- R5: Area a (a ≥ 4) takes its wait count from bits [2(a−4)+1 : 2(a−4)] of the upper wait register. Area a (a < 4) takes it from bits [2a+1 : 2a] of the lower wait register. A three-state access runs T1, T2, then that many Tw states (0 to 3), then T3.
- R6: A two-state access inserts no Tw, whatever its wait count.
- R7: An on-chip access (`acc_onchip`=1) always runs T1, T2 and ignores all three registers. If `acc_dram` is also set, the on-chip flag wins.
- R8: A DRAM access (`acc_dram`=1, `acc_onchip`=0) produces no bus states and no `acc_done`, whatever the register settings. Instead, `dram_req` is high for the one cycle after the accepting edge.
- R9: `bus_state` is bit 0 = T1, bit 1 = T2, bit 2 = Tw, bit 3 = T3. It is one-hot during an access and zero when idle. The first state follows the accepting edge. `acc_done` is high for exactly the one cycle of the final state.
- R10: `acc_ready` is high only when idle and neither standby input is high. A request presented while `acc_ready` is low is ignored, and a request held high is taken on the first cycle that `acc_ready` returns.
- R11: An access uses the register values from before its accepting edge. A write on that edge, or during the access, takes effect from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: registers to 0xFF, sequencer to idle |
| sw_stby | input | 1 | Software standby: registers kept, no new access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be taken |
| acc_area | input | 3 | Area number of the access |
| acc_onchip | input | 1 | Access targets on-chip memory or registers |
| acc_dram | input | 1 | Access targets a DRAM area |
| bus_state | output | 4 | One-hot bus state: T1, T2, Tw, T3 |
| acc_done | output | 1 | One-cycle pulse in the final state |
| dram_req | output | 1 | One-cycle hand-off pulse for DRAM accesses |

## Verification
The bench covers every area under several patterns of access-length bits and wait counts, including a wait count of 3 on a two-state area. A design that reads the wrong bit pair, or that adds waits to two-state accesses, shows a wrong state sequence there. It also writes registers in the same cycle an access is accepted, and in the middle of an access. A design that does not freeze the settings at acceptance changes the running access or the wrong one. Other cases are a request held high through a busy period, requests during software standby, on-chip and DRAM flags set together, and hardware standby raised in the middle of an access together with a write. A design that gets these wrong starts a second access, loses the held request, chooses the DRAM path, or keeps the written value instead of 0xFF.

// File: rtl/ebsc_pkg.sv
package ebsc_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4
  } seq_state_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LEN   = 2'd0;
  localparam logic [ADDR_W-1:0] A_WAITH = 2'd1;
  localparam logic [ADDR_W-1:0] A_WAITL = 2'd2;

  localparam int unsigned BS_T1 = 0;
  localparam int unsigned BS_T2 = 1;
  localparam int unsigned BS_TW = 2;
  localparam int unsigned BS_T3 = 3;
  localparam int unsigned BS_W  = 4;

endpackage

// File: rtl/bus_cfg_regs.sv
module bus_cfg_regs
  import ebsc_pkg::*;
#(
  parameter int unsigned NUM_AREAS = 8,
  parameter int unsigned WAIT_W    = 2,
  localparam int unsigned REG_W    = NUM_AREAS,
  localparam int unsigned WVEC_W   = NUM_AREAS * WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  len_bits,
  output logic [WVEC_W-1:0] wait_vec
);

  logic [REG_W-1:0] len_q;
  logic [REG_W-1:0] wh_q;
  logic [REG_W-1:0] wl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '1;
      wh_q  <= '1;
      wl_q  <= '1;
    end else if (hw_stby) begin
      len_q <= '1;
      wh_q  <= '1;
      wl_q  <= '1;
    end else if (wr_en) begin
      case (addr)
        A_LEN:   len_q <= wdata;
        A_WAITH: wh_q  <= wdata;
        A_WAITL: wl_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_LEN:   rdata = len_q;
      A_WAITH: rdata = wh_q;
      A_WAITL: rdata = wl_q;
      default: rdata = '0;
    endcase
  end

  assign len_bits = len_q;
  assign wait_vec = {wh_q, wl_q};

  // R2: hardware standby forces every register to all ones
  p_hw_stby_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (&len_q && &wh_q && &wl_q));

  // R3: software standby alone never alters the registers
  p_sw_stby_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby && !wr_en) |=> ($stable(len_q) && $stable(wh_q) && $stable(wl_q)));

endmodule

// File: rtl/area_plan_sel.sv
module area_plan_sel #(
  parameter int unsigned NUM_AREAS = 8,
  parameter int unsigned WAIT_W    = 2,
  localparam int unsigned AREA_W   = $clog2(NUM_AREAS),
  localparam int unsigned WVEC_W   = NUM_AREAS * WAIT_W
) (
  input  logic [AREA_W-1:0]    area,
  input  logic                 onchip,
  input  logic                 dram,
  input  logic [NUM_AREAS-1:0] len_bits,
  input  logic [WVEC_W-1:0]    wait_vec,
  output logic                 long_acc,
  output logic [WAIT_W-1:0]    wait_cnt,
  output logic                 to_dram
);

  logic [WAIT_W-1:0] area_wait [NUM_AREAS];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    assign area_wait[g] = wait_vec[g*WAIT_W +: WAIT_W];
  end

  always_comb begin
    long_acc = 1'b0;
    wait_cnt = '0;
    to_dram  = 1'b0;
    if (onchip) begin
      long_acc = 1'b0;
    end else if (dram) begin
      to_dram = 1'b1;
    end else begin
      long_acc = len_bits[area];
      wait_cnt = len_bits[area] ? area_wait[area] : '0;
    end
  end

endmodule

// File: rtl/access_sequencer.sv
module access_sequencer
  import ebsc_pkg::*;
#(
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              plan_long,
  input  logic [WAIT_W-1:0] plan_wait,
  input  logic              plan_dram,
  output logic [BS_W-1:0]   bus_state,
  output logic              done,
  output logic              dram_req
);

  seq_state_e        state;
  logic              lat_long;
  logic [WAIT_W-1:0] lat_wait;
  logic [WAIT_W-1:0] wait_left;
  logic              accept;

  assign req_ready = (state == S_IDLE) && !sw_stby && !hw_stby;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lat_long  <= 1'b0;
      lat_wait  <= '0;
      wait_left <= '0;
      dram_req  <= 1'b0;
    end else if (hw_stby) begin
      state     <= S_IDLE;
      wait_left <= '0;
      dram_req  <= 1'b0;
    end else begin
      dram_req <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (plan_dram) begin
              dram_req <= 1'b1;
            end else begin
              state    <= S_T1;
              lat_long <= plan_long;
              lat_wait <= plan_wait;
            end
          end
        end
        S_T1: begin
          state     <= S_T2;
          wait_left <= lat_wait;
        end
        S_T2: begin
          if (!lat_long)            state <= S_IDLE;
          else if (wait_left != '0) state <= S_TW;
          else                      state <= S_T3;
        end
        S_TW: begin
          wait_left <= wait_left - 1'b1;
          if (wait_left == WAIT_W'(1)) state <= S_T3;
        end
        S_T3:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_state = '0;
    case (state)
      S_T1:    bus_state[BS_T1] = 1'b1;
      S_T2:    bus_state[BS_T2] = 1'b1;
      S_TW:    bus_state[BS_TW] = 1'b1;
      S_T3:    bus_state[BS_T3] = 1'b1;
      default: bus_state = '0;
    endcase
  end

  assign done = (state == S_T3) || ((state == S_T2) && !lat_long);

  // R9: never more than one bus state at a time
  p_onehot_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_state));

  // R9: done only in T2 or T3
  p_done_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_state[BS_T3] || bus_state[BS_T2]));

  // R10: an access can only begin after the port was ready
  p_start_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_state[BS_T1]) |-> $past(req_ready));

  // R4: T1 is always followed by T2 unless standby aborts
  p_t1_then_t2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state[BS_T1] && !hw_stby) |=> bus_state[BS_T2]);

  // R6: wait states only appear in long accesses
  p_tw_long_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state[BS_TW] |-> lat_long);

  // R8: DRAM hand-off happens with the bus idle
  p_dram_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req |-> (bus_state == '0 && !done));

endmodule

// File: rtl/ext_bus_state_ctrl.sv
module ext_bus_state_ctrl
  import ebsc_pkg::*;
#(
  parameter int unsigned NUM_AREAS = 8,
  parameter int unsigned WAIT_W    = 2,
  localparam int unsigned AREA_W   = $clog2(NUM_AREAS),
  localparam int unsigned REG_W    = NUM_AREAS,
  localparam int unsigned WVEC_W   = NUM_AREAS * WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [AREA_W-1:0] acc_area,
  input  logic              acc_onchip,
  input  logic              acc_dram,
  output logic [BS_W-1:0]   bus_state,
  output logic              acc_done,
  output logic              dram_req
);

  logic [REG_W-1:0]  len_bits;
  logic [WVEC_W-1:0] wait_vec;
  logic              plan_long;
  logic [WAIT_W-1:0] plan_wait;
  logic              plan_dram;

  bus_cfg_regs #(
    .NUM_AREAS(NUM_AREAS),
    .WAIT_W   (WAIT_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .sw_stby (sw_stby),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .len_bits(len_bits),
    .wait_vec(wait_vec)
  );

  area_plan_sel #(
    .NUM_AREAS(NUM_AREAS),
    .WAIT_W   (WAIT_W)
  ) u_sel (
    .area    (acc_area),
    .onchip  (acc_onchip),
    .dram    (acc_dram),
    .len_bits(len_bits),
    .wait_vec(wait_vec),
    .long_acc(plan_long),
    .wait_cnt(plan_wait),
    .to_dram (plan_dram)
  );

  access_sequencer #(
    .WAIT_W(WAIT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_stby  (hw_stby),
    .sw_stby  (sw_stby),
    .req_valid(acc_valid),
    .req_ready(acc_ready),
    .plan_long(plan_long),
    .plan_wait(plan_wait),
    .plan_dram(plan_dram),
    .bus_state(bus_state),
    .done     (acc_done),
    .dram_req (dram_req)
  );

  // R10: no readiness while either standby input is active
  p_stby_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby || hw_stby) |-> !acc_ready);

  // R7: an on-chip request taken never hands off to DRAM
  p_onchip_no_dram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_onchip) |=> !dram_req);

endmodule

// File: tb/ext_bus_state_ctrl_tb.sv
module ext_bus_state_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0;
  logic       sw_stby = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic [2:0] acc_area = 3'd0;
  logic       acc_onchip = 1'b0;
  logic       acc_dram = 1'b0;
  logic [3:0] bus_state;
  logic       acc_done;
  logic       dram_req;

  always #4 clk = ~clk;

  ext_bus_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_area(acc_area), .acc_onchip(acc_onchip), .acc_dram(acc_dram),
    .bus_state(bus_state), .acc_done(acc_done), .dram_req(dram_req)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R2";

  // reference model: expected output codes per cycle, bit 4 = done
  int         q[$];
  int         cur = 0;
  bit         m_dram = 1'b0;
  logic [7:0] m_len = 8'hFF;
  logic [7:0] m_wh = 8'hFF;
  logic [7:0] m_wl = 8'hFF;
  bit         m_rdy;
  int         w;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = 0; m_dram = 1'b0;
      m_len = 8'hFF; m_wh = 8'hFF; m_wl = 8'hFF;
    end else begin
      m_rdy = (cur == 0) && !sw_stby && !hw_stby;
      m_dram = 1'b0;
      if (hw_stby) begin
        q.delete();
        m_len = 8'hFF; m_wh = 8'hFF; m_wl = 8'hFF;
        cur = 0;
      end else begin
        if (acc_valid && m_rdy) begin
          if (acc_onchip) begin
            q.push_back(1); q.push_back(2 | 16);
          end else if (acc_dram) begin
            m_dram = 1'b1;
          end else if (m_len[acc_area]) begin
            if (acc_area >= 4) w = int'((m_wh >> (2 * (acc_area - 4))) & 8'd3);
            else               w = int'((m_wl >> (2 * acc_area)) & 8'd3);
            q.push_back(1); q.push_back(2);
            for (int k = 0; k < w; k++) q.push_back(4);
            q.push_back(8 | 16);
          end else begin
            q.push_back(1); q.push_back(2 | 16);
          end
        end
        if (reg_wr) begin
          case (reg_addr)
            2'd0: m_len = reg_wdata;
            2'd1: m_wh  = reg_wdata;
            2'd2: m_wl  = reg_wdata;
            default: ;
          endcase
        end
        cur = (q.size() > 0) ? q.pop_front() : 0;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("bus_state", int'(bus_state), cur & 15);
    chk("acc_done", int'(acc_done), (cur >> 4) & 1);
    chk("dram_req", int'(dram_req), int'(m_dram));
    chk("acc_ready", int'(acc_ready),
        int'(rst_n ? ((cur == 0) && !sw_stby && !hw_stby) : !sw_stby && !hw_stby));
    case (reg_addr)
      2'd0: chk("reg_rdata", int'(reg_rdata), int'(m_len));
      2'd1: chk("reg_rdata", int'(reg_rdata), int'(m_wh));
      2'd2: chk("reg_rdata", int'(reg_rdata), int'(m_wl));
      default: chk("reg_rdata", int'(reg_rdata), 0);
    endcase
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
    tick();
  endtask

  task automatic access(input logic [2:0] a, input logic onc, input logic dr);
    acc_valid = 1'b1; acc_area = a; acc_onchip = onc; acc_dram = dr;
    tick();
    acc_valid = 1'b0; acc_onchip = 1'b0; acc_dram = 1'b0;
    repeat (8) tick();
  endtask

  task automatic sweep(input logic onc, input logic dr);
    for (int a = 0; a < 8; a++) access(3'(a), onc, dr);
  endtask

  bit finished = 1'b0;

  initial begin
    phase = "R2";
    repeat (3) tick();
    for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); tick(); end
    rst_n = 1'b1;
    tick();

    phase = "R1";
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h1B);
    wr(2'd2, 8'hE4);
    wr(2'd3, 8'h55);
    for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); tick(); end

    phase = "R4";
    sweep(1'b0, 1'b0);

    phase = "R5";
    wr(2'd0, 8'hFF);
    sweep(1'b0, 1'b0);
    wr(2'd1, 8'hE4);
    wr(2'd2, 8'h1B);
    sweep(1'b0, 1'b0);

    phase = "R6";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    sweep(1'b0, 1'b0);
    wr(2'd0, 8'h5A);
    sweep(1'b0, 1'b0);

    phase = "R7";
    wr(2'd0, 8'hFF);
    sweep(1'b1, 1'b0);
    sweep(1'b1, 1'b1);

    phase = "R8";
    sweep(1'b0, 1'b1);
    wr(2'd0, 8'h00);
    sweep(1'b0, 1'b1);

    phase = "R10";
    wr(2'd0, 8'hFF);
    acc_valid = 1'b1; acc_area = 3'd3;
    repeat (20) tick();
    acc_area = 3'd0;
    repeat (7) tick();
    acc_valid = 1'b0;
    repeat (8) tick();

    phase = "R11";
    acc_valid = 1'b1; acc_area = 3'd3;
    tick();
    acc_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
    tick();
    reg_wr = 1'b0;
    repeat (7) tick();
    access(3'd3, 1'b0, 1'b0);
    acc_valid = 1'b1; acc_area = 3'd3;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hFF;
    tick();
    acc_valid = 1'b0; reg_wr = 1'b0;
    repeat (8) tick();
    access(3'd3, 1'b0, 1'b0);

    phase = "R3";
    wr(2'd1, 8'h6C);
    sw_stby = 1'b1;
    acc_valid = 1'b1; acc_area = 3'd5;
    for (int a = 0; a < 3; a++) begin reg_addr = 2'(a); repeat (3) tick(); end
    acc_valid = 1'b0;
    sw_stby = 1'b0;
    reg_addr = 2'd1;
    tick();
    access(3'd5, 1'b0, 1'b0);

    phase = "R2";
    wr(2'd0, 8'h3C);
    acc_valid = 1'b1; acc_area = 3'd2;
    tick();
    acc_valid = 1'b0;
    tick();
    hw_stby = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h12;
    tick();
    reg_wr = 1'b0; acc_valid = 1'b1; acc_area = 3'd4;
    tick();
    hw_stby = 1'b0; acc_valid = 1'b0;
    tick();
    access(3'd4, 1'b0, 1'b0);
    for (int a = 0; a < 3; a++) begin reg_addr = 2'(a); tick(); end

    phase = "R9";
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'hC6);
    sweep(1'b0, 1'b0);

    repeat (4) tick();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule